// File: doc/BRIEF.md
# DMA Controller Register Control Unit

This block is the control-register front end of one four-channel DMA controller. It decodes byte-wide register accesses in the upper half of the controller's register window. It keeps the command byte, the channel mask byte, the per-channel mode bytes and a status byte that holds terminal-count and request flags. It also provides a readback counter that walks the mode bytes, and a master-clear action that returns the control state to idle.

Alongside the stored state, the unit gives the surrounding controller the information it needs to run. It exports every channel's mode byte, a one-cycle pulse telling the address datapath to clear or set its byte-pointer flip-flop, and a per-channel vector of channels that may be serviced now. It also exports the lowest-numbered of those channels. Terminal-count pulses and request levels from the channel logic feed the status byte directly.

An access is presented for one clock with `wr_en` or `rd_en` high. Read data is combinational during that cycle. All side effects, including read side effects, take effect at the clock edge that ends the access.

Top module: `dma_ctl_unit`

## Requirements
- R1: After reset, the command byte is 0x00, the status byte is 0x00, the mask byte is 0xFF, every mode byte is 0x00, the mode readback counter is 0, and `svc_en` is 0.
- R2: A write at index 8 is dropped whole if the data has any of bits 0, 1, 3, 5, 6 or 7 set. Otherwise the byte is stored. A read at index 10 returns the stored command byte.
- R3: A write at index 9 selects a channel with bits 1:0. It sets that channel's request flag (status bit channel+4) to data bit 2, and it always clears that channel's terminal-count flag (status bit channel).
- R4: A write at index 10 selects a channel with bits 1:0 and sets that channel's mask bit (mask bit channel) to data bit 2. A read at index 15 returns the whole mask byte.
- R5: A write at index 15 stores the whole data byte as the mask. A write at index 14 clears the mask to 0x00.
- R6: A write at index 11 stores the whole data byte as the mode of the channel in bits 1:0. Channel n's mode appears on `mode_flat[8n+7:8n]`.
- R7: A read at index 11 returns the mode byte of the channel chosen by the readback counter, with bits 1:0 forced to 1. The counter then advances modulo 4, and `bptr_set` pulses during the access.
- R8: A read at index 14 returns 0x00 and sets the readback counter to 0.
- R9: A read at index 8 returns the whole status byte. Afterwards, bits 3:0 are cleared and bits 7:4 are kept.
- R10: A read at index 9 returns the status request nibble in bits 3:0, with bits 7:4 forced to 1.
- R11: A write at index 13 (master clear) zeroes the command byte, the status byte and the readback counter, sets the mask to 0xFF, pulses `bptr_clr`, and leaves the mode bytes unchanged.
- R12: `bptr_clr` pulses on a write at index 12, and `bptr_set` pulses on a read at index 12. Reads at indices 12 and 13 return 0x00. An access with index bit 3 at 0 produces no pulse and changes no register.
- R13: When `req_lvl[n]` changes, status bit n+4 takes its new level at that cycle's edge. A `tc_pulse[n]` sets status bit n. If a status read would clear that bit in the same cycle, the pulse wins.
- R14: `svc_en[n]` is 1 exactly when command bit 2 is 0, mask bit n is 0 and request flag n is 1. `svc_first` is the lowest set bit of `svc_en`, or 0 when none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 4 | Register index after width shift; only indices 8 to 15 are decoded |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| req_lvl | input | 4 | Per-channel request level from the channel logic |
| tc_pulse | input | 4 | Per-channel terminal-count pulse |
| rd_data | output | 8 | Read data, valid while `rd_en` is high |
| mode_flat | output | 32 | Mode bytes, channel n in bits 8n+7:8n |
| bptr_clr | output | 1 | Pulse: clear the byte-pointer flip-flop |
| bptr_set | output | 1 | Pulse: set the byte-pointer flip-flop |
| svc_en | output | 4 | Channels eligible for service |
| svc_first | output | 4 | One-hot lowest eligible channel |

## Verification
The embedded properties check, on every cycle, the state rules that follow from one access. A terminal-count pulse always lands in status. A plain status read empties the terminal-count nibble. Master clear leaves status at zero and the mask at all ones. A rejected command write leaves the command unchanged. The readback counter either steps by one or returns to zero. The service outputs stay one-hot and consistent with a disabled controller. What only the bench scenarios can show is the value behind those rules: the exhaustive command-acceptance sweep, the exact bytes returned by each read index, the mode readback order with wrap-around, the pulse-over-clear collision, and the full cross of mask, request and disable against the eligibility and priority outputs.

// File: rtl/dma_ctl_pkg.sv
// Shared constants and strobe types for the DMA control-register unit.
// Assumes a 4-channel controller with byte-wide registers.
package dma_ctl_pkg;
    localparam int NCH = 4;
    localparam int DW  = 8;
    // Command bits this unit does not implement; any of them rejects the write.
    localparam logic [7:0] CMD_UNSUP  = 8'hEB;
    localparam int         CMD_OFF_BIT = 2;

    typedef enum logic [2:0] {
        W_CMD, W_REQ, W_MASK1, W_MODE, W_BPCLR, W_MCLR, W_MASKCLR, W_MASKALL
    } wr_op_e;

    typedef enum logic [2:0] {
        R_STAT, R_REQF, R_CMD, R_MODE, R_BPSET, R_TEMP, R_CTRCLR, R_MASK
    } rd_op_e;

    typedef struct packed {
        logic cmd, req, mask1, mode, bpclr, mclr, maskclr, maskall;
    } wr_stb_t;

    typedef struct packed {
        logic stat, reqf, cmd, mode, bpset, temp, ctrclr, mask;
    } rd_stb_t;
endpackage

// File: rtl/dma_ctl_decode.sv
// Access decoder: turns an index plus strobes into one-hot operation strobes.
// Assumes only indices with bit 3 set belong to this unit; others decode to nothing.
module dma_ctl_decode
    import dma_ctl_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic             rd_en,
    output wr_stb_t          wr_stb,
    output rd_stb_t          rd_stb
);
    localparam int OP_W = 3;
    logic              in_win;
    logic [OP_W-1:0]   op;

    assign in_win = idx[IDX_W-1];
    assign op     = idx[OP_W-1:0];

    // Write operation decode.
    always_comb begin
        wr_stb = '0;
        if (wr_en && in_win) begin
            case (op)
                W_CMD:     wr_stb.cmd     = 1'b1;
                W_REQ:     wr_stb.req     = 1'b1;
                W_MASK1:   wr_stb.mask1   = 1'b1;
                W_MODE:    wr_stb.mode    = 1'b1;
                W_BPCLR:   wr_stb.bpclr   = 1'b1;
                W_MCLR:    wr_stb.mclr    = 1'b1;
                W_MASKCLR: wr_stb.maskclr = 1'b1;
                default:   wr_stb.maskall = 1'b1;
            endcase
        end
    end

    // Read operation decode.
    always_comb begin
        rd_stb = '0;
        if (rd_en && in_win) begin
            case (op)
                R_STAT:   rd_stb.stat   = 1'b1;
                R_REQF:   rd_stb.reqf   = 1'b1;
                R_CMD:    rd_stb.cmd    = 1'b1;
                R_MODE:   rd_stb.mode   = 1'b1;
                R_BPSET:  rd_stb.bpset  = 1'b1;
                R_TEMP:   rd_stb.temp   = 1'b1;
                R_CTRCLR: rd_stb.ctrclr = 1'b1;
                default:  rd_stb.mask   = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dma_ctl_status.sv
// Status byte: terminal-count flags in the low half, request flags in the high half.
// Assumes at most one register access per cycle. Update priority, lowest first:
// read-clear, request write, request-level change, terminal-count pulse, master clear.
module dma_ctl_status #(
    parameter int NCH  = 4,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_stat,
    input  logic             wr_req,
    input  logic [CH_W:0]    req_cmd,
    input  logic             mclr,
    input  logic [NCH-1:0]   req_lvl,
    input  logic [NCH-1:0]   tc_pulse,
    output logic [2*NCH-1:0] stat_q
);
    logic [NCH-1:0]   req_prev_q;
    logic [NCH-1:0]   req_chg;
    logic [2*NCH-1:0] stat_nxt;

    assign req_chg = req_lvl ^ req_prev_q;

    // Next status value built up in priority order.
    always_comb begin
        stat_nxt = stat_q;
        if (rd_stat) stat_nxt[NCH-1:0] = '0;
        for (int i = 0; i < NCH; i++) begin
            if (wr_req && (req_cmd[CH_W-1:0] == CH_W'(i))) begin
                stat_nxt[NCH+i] = req_cmd[CH_W];
                stat_nxt[i]     = 1'b0;
            end
            if (req_chg[i]) stat_nxt[NCH+i] = req_lvl[i];
        end
        stat_nxt[NCH-1:0] = stat_nxt[NCH-1:0] | tc_pulse;
        if (mclr) stat_nxt = '0;
    end

    // Status and request-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q     <= '0;
            req_prev_q <= '0;
        end else begin
            stat_q     <= stat_nxt;
            req_prev_q <= req_lvl;
        end
    end

    // R13
    tc_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclr && (|tc_pulse)) |=> ((stat_q[NCH-1:0] & $past(tc_pulse)) == $past(tc_pulse)));
    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && (tc_pulse == '0)) |=> (stat_q[NCH-1:0] == '0));
    // R11
    mclr_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (stat_q == '0));
endmodule

// File: rtl/dma_ctl_mode_bank.sv
// Per-channel mode bytes plus the self-incrementing readback pointer.
// Assumes mode bytes are reset only by rst_n; master clear resets the pointer only.
module dma_ctl_mode_bank #(
    parameter int NCH  = 4,
    parameter int DW   = 8,
    parameter int CH_W = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_mode,
    input  logic              rd_ctrclr,
    input  logic              mclr,
    output logic [NCH*DW-1:0] mode_flat,
    output logic [DW-1:0]     mode_rd
);
    localparam logic [DW-1:0] RD_FORCE = DW'((1 << CH_W) - 1);
    logic [DW-1:0]   mode_q [NCH];
    logic [CH_W-1:0] ctr_q;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Mode byte of channel g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_q[g] <= '0;
            else if (wr_mode && (wr_data[CH_W-1:0] == CH_W'(g)))
                mode_q[g] <= wr_data;
        end
        assign mode_flat[g*DW +: DW] = mode_q[g];
    end

    // Readback pointer: cleared by master clear or pointer-clear read, steps on mode read.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr || rd_ctrclr)
            ctr_q <= '0;
        else if (rd_mode)
            ctr_q <= ctr_q + 1'b1;
    end

    assign mode_rd = mode_q[ctr_q] | RD_FORCE;

    // R7
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode && !rd_ctrclr && !mclr) |=> (ctr_q == CH_W'($past(ctr_q) + 1'b1)));
    // R8
    ctr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrclr || mclr) |=> (ctr_q == '0));
endmodule

// File: rtl/dma_ctl_service.sv
// Service eligibility: unmasked channels with a pending request, gated by controller disable,
// and the lowest-numbered eligible channel as a one-hot pick.
module dma_ctl_service #(
    parameter int NCH = 4
) (
    input  logic           ctl_off,
    input  logic [NCH-1:0] mask,
    input  logic [NCH-1:0] reqf,
    output logic [NCH-1:0] svc_en,
    output logic [NCH-1:0] svc_first
);
    assign svc_en = ctl_off ? '0 : (reqf & ~mask);

    // Fixed-order pick: scanning high to low leaves the lowest set bit.
    always_comb begin
        svc_first = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (svc_en[i]) svc_first = NCH'(1) << i;
        end
    end
endmodule

// File: rtl/dma_ctl_unit.sv
// DMA control-register unit top: command and mask registers, read multiplexer,
// byte-pointer pulses, and wiring of the decoder, status, mode bank and service logic.
// Assumes one access per cycle; read data is combinational, side effects land at the edge.
module dma_ctl_unit
    import dma_ctl_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wr_data,
    input  logic [NCH-1:0]    req_lvl,
    input  logic [NCH-1:0]    tc_pulse,
    output logic [DW-1:0]     rd_data,
    output logic [NCH*DW-1:0] mode_flat,
    output logic              bptr_clr,
    output logic              bptr_set,
    output logic [NCH-1:0]    svc_en,
    output logic [NCH-1:0]    svc_first
);
    localparam int CH_W = $clog2(NCH);

    wr_stb_t        wr_stb;
    rd_stb_t        rd_stb;
    logic [DW-1:0]  cmd_q;
    logic [DW-1:0]  mask_q;
    logic [2*NCH-1:0] stat_q;
    logic [DW-1:0]  mode_rd;

    dma_ctl_decode #(.IDX_W(IDX_W)) u_dec (
        .idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
        .wr_stb(wr_stb), .rd_stb(rd_stb)
    );

    dma_ctl_status #(.NCH(NCH)) u_stat (
        .clk(clk), .rst_n(rst_n), .rd_stat(rd_stb.stat), .wr_req(wr_stb.req),
        .req_cmd(wr_data[CH_W:0]), .mclr(wr_stb.mclr), .req_lvl(req_lvl),
        .tc_pulse(tc_pulse), .stat_q(stat_q)
    );

    dma_ctl_mode_bank #(.NCH(NCH), .DW(DW)) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_stb.mode), .wr_data(wr_data),
        .rd_mode(rd_stb.mode), .rd_ctrclr(rd_stb.ctrclr), .mclr(wr_stb.mclr),
        .mode_flat(mode_flat), .mode_rd(mode_rd)
    );

    dma_ctl_service #(.NCH(NCH)) u_svc (
        .ctl_off(cmd_q[CMD_OFF_BIT]), .mask(mask_q[NCH-1:0]), .reqf(stat_q[2*NCH-1:NCH]),
        .svc_en(svc_en), .svc_first(svc_first)
    );

    // Command register: accepts only writes free of unsupported feature bits.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_stb.mclr)
            cmd_q <= '0;
        else if (wr_stb.cmd && ((wr_data & CMD_UNSUP) == '0))
            cmd_q <= wr_data;
    end

    // Mask register: whole-byte write, clear-all, or single-channel update.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_stb.mclr)
            mask_q <= '1;
        else if (wr_stb.maskall)
            mask_q <= wr_data;
        else if (wr_stb.maskclr)
            mask_q <= '0;
        else if (wr_stb.mask1)
            mask_q[wr_data[CH_W-1:0]] <= wr_data[CH_W];
    end

    // Byte-pointer control pulses for the address datapath.
    assign bptr_clr = wr_stb.bpclr | wr_stb.mclr;
    assign bptr_set = rd_stb.bpset | rd_stb.mode;

    // Read data multiplexer; temporary register and action-only reads return zero.
    always_comb begin
        rd_data = '0;
        if (rd_stb.stat)        rd_data = DW'(stat_q);
        else if (rd_stb.reqf)   rd_data = {{(DW-NCH){1'b1}}, stat_q[2*NCH-1:NCH]};
        else if (rd_stb.cmd)    rd_data = cmd_q;
        else if (rd_stb.mode)   rd_data = mode_rd;
        else if (rd_stb.mask)   rd_data = mask_q;
        else if (rd_stb.temp || rd_stb.bpset || rd_stb.ctrclr) rd_data = '0;
    end

    // R2
    cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb.cmd && ((wr_data & CMD_UNSUP) != '0)) |=> $stable(cmd_q));
    // R11
    mask_mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb.mclr |=> (mask_q == '1));
    // R14
    svc_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(svc_first) && ((svc_first & ~svc_en) == '0));
    // R14
    svc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[CMD_OFF_BIT] |-> (svc_en == '0));
endmodule

// File: tb/dma_ctl_unit_bench.sv
`timescale 1ns/1ps
module dma_ctl_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  req_lvl = '0;
    logic [3:0]  tc_pulse = '0;
    logic [7:0]  rd_data;
    logic [31:0] mode_flat;
    logic        bptr_clr, bptr_set;
    logic [3:0]  svc_en, svc_first;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    logic p_clr, p_set;

    logic [7:0] m_cmd, m_stat, m_mask;
    logic [7:0] m_mode [4];
    int         m_ctr;

    always #2.5 clk = ~clk;

    dma_ctl_unit u_dma_ctl_unit (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .req_lvl(req_lvl), .tc_pulse(tc_pulse), .rd_data(rd_data),
        .mode_flat(mode_flat), .bptr_clr(bptr_clr), .bptr_set(bptr_set),
        .svc_en(svc_en), .svc_first(svc_first)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [7:0] d);
        @(negedge clk);
        reg_idx = i; wr_data = d; wr_en = 1'b1;
        #1 p_clr = bptr_clr; p_set = bptr_set;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] i, output logic [7:0] d);
        @(negedge clk);
        reg_idx = i; rd_en = 1'b1;
        #1 d = rd_data; p_clr = bptr_clr; p_set = bptr_set;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_tc(input logic [3:0] t);
        @(negedge clk);
        tc_pulse = t;
        @(negedge clk);
        tc_pulse = '0;
    endtask

    function automatic logic [31:0] modes_exp();
        return {m_mode[3], m_mode[2], m_mode[1], m_mode[0]};
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        m_cmd = 8'h00; m_stat = 8'h00; m_mask = 8'hFF; m_ctr = 0;
        for (int c = 0; c < 4; c++) m_mode[c] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 svc_en", svc_en, 0);
        chk("R1 modes", mode_flat, 0);
        rd(8, d);  chk("R1 status", d, 8'h00);
        rd(10, d); chk("R1 command", d, 8'h00);
        rd(15, d); chk("R1 mask", d, 8'hFF);
        rd(11, d); chk("R1 mode read ch0", d, 8'h03);
        rd(14, d); chk("R8 ctr clear read", d, 8'h00);

        // R2 full command sweep
        for (int v = 0; v < 256; v++) begin
            wr(8, 8'(v));
            if ((8'(v) & 8'hEB) == 8'h00) m_cmd = 8'(v);
            rd(10, d);
            chk("R2 command", d, m_cmd);
        end
        wr(8, 8'h00); m_cmd = 8'h00;

        // R3 request writes, R9 status read clear, R10 request flag read
        for (int v = 0; v < 8; v++) begin
            pulse_tc(4'hF);
            m_stat[3:0] = 4'hF;
            wr(9, 8'(v));
            m_stat[4 + (v % 4)] = (v >= 4);
            m_stat[v % 4] = 1'b0;
            rd(8, d);
            chk("R3 status after request write", d, m_stat);
            m_stat[3:0] = 4'h0;
            rd(8, d);
            chk("R9 status tc cleared", d, m_stat);
            rd(9, d);
            chk("R10 request flags", d, {4'hF, m_stat[7:4]});
        end

        // R4 single mask bit writes
        for (int v = 0; v < 8; v++) begin
            wr(10, 8'(v));
            m_mask[v % 4] = (v >= 4);
            rd(15, d);
            chk("R4 mask", d, m_mask);
        end

        // R5 whole mask write and clear-all
        wr(15, 8'hA5); rd(15, d); chk("R5 mask all", d, 8'hA5);
        wr(14, 8'h5A); rd(15, d); chk("R5 mask clear", d, 8'h00);
        m_mask = 8'h00;

        // R6 mode writes
        for (int c = 0; c < 4; c++) begin
            logic [7:0] b;
            b = ((8'h1C + 8'(c) * 8'h47) & 8'hFC) | 8'(c);
            wr(11, b);
            m_mode[c] = b;
            #1 chk("R6 mode bytes", mode_flat, modes_exp());
        end

        // R7 mode readback walk with wrap, R8 counter clear
        for (int k = 0; k < 6; k++) begin
            rd(11, d);
            chk("R7 mode read", d, m_mode[m_ctr] | 8'h03);
            chk("R7 bptr_set on mode read", p_set, 1);
            m_ctr = (m_ctr + 1) % 4;
        end
        rd(14, d); m_ctr = 0;
        rd(11, d); chk("R8 read after counter clear", d, m_mode[0] | 8'h03);
        m_ctr = 1;

        // R12 byte pointer pulses and out-of-window accesses
        wr(12, 8'h00); chk("R12 bptr_clr on write", p_clr, 1);
        rd(12, d);     chk("R12 bptr_set on read", p_set, 1);
        chk("R12 set read data", d, 8'h00);
        rd(13, d);     chk("R12 temp read data", d, 8'h00);
        wr(0, 8'h04);  chk("R12 no pulse low index", p_clr, 0);
        wr(3, 8'hFF);  chk("R12 no pulse low index mask", p_clr, 0);
        rd(10, d);     chk("R12 command untouched", d, m_cmd);
        rd(15, d);     chk("R12 mask untouched", d, m_mask);
        chk("R12 modes untouched", mode_flat, modes_exp());

        // R11 master clear
        wr(8, 8'h10); m_cmd = 8'h10;
        pulse_tc(4'h6);
        wr(13, 8'h00);
        chk("R11 bptr_clr on master clear", p_clr, 1);
        m_cmd = 8'h00; m_stat = 8'h00; m_mask = 8'hFF; m_ctr = 0;
        rd(10, d); chk("R11 command", d, 8'h00);
        rd(8, d);  chk("R11 status", d, 8'h00);
        rd(15, d); chk("R11 mask", d, 8'hFF);
        chk("R11 modes kept", mode_flat, modes_exp());
        rd(11, d); chk("R11 counter zero", d, m_mode[0] | 8'h03);

        // R13 request levels and pulse-over-clear collision
        @(negedge clk); req_lvl = 4'b0101;
        @(negedge clk);
        rd(9, d); chk("R13 level rise", d, 8'hF5);
        @(negedge clk); req_lvl = 4'b0100;
        @(negedge clk);
        rd(9, d); chk("R13 level fall", d, 8'hF4);
        m_stat = 8'h40;
        @(negedge clk);
        reg_idx = 4'd8; rd_en = 1'b1; tc_pulse = 4'b0010;
        #1 chk("R9 status read value", rd_data, m_stat);
        @(negedge clk);
        rd_en = 1'b0; tc_pulse = '0;
        m_stat = 8'h42;
        rd(8, d); chk("R13 pulse beats read clear", d, m_stat);
        @(negedge clk); req_lvl = 4'b0000;
        @(negedge clk);
        rd(9, d); chk("R13 level cleared", d, 8'hF0);

        // R14 cross of disable, mask and request
        for (int dis = 0; dis < 2; dis++) begin
            for (int mk = 0; mk < 16; mk++) begin
                for (int rq = 0; rq < 16; rq++) begin
                    logic [3:0] e_en, e_first;
                    @(negedge clk); req_lvl = 4'(rq);
                    wr(8, 8'(dis << 2));
                    wr(15, 8'(mk));
                    e_en = (dis != 0) ? 4'h0 : (4'(rq) & ~4'(mk));
                    e_first = e_en & (~e_en + 4'd1);
                    #1;
                    chk("R14 svc_en", svc_en, e_en);
                    chk("R14 svc_first", svc_first, e_first);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule